// File: doc/BRIEF.md
# Translation Lookaside Buffer with Access-Right Check

This block is a small, fully associative cache of page translations that sits between the address source and the memory system. Each cycle it can take one lookup. A lookup carries a 32-bit virtual address, a write/read flag and a user/supervisor flag. The 20-bit page number is compared against every stored entry at once. When an entry matches and the stored rights allow the access, the physical address comes back in the same cycle. That address is the stored frame number joined to the untouched 12-bit page offset, since pages are 4 KB.

If no entry matches, the block reports a miss and the external walker resolves the translation. The walker then installs the result through the fill port. A matching entry whose rights forbid the access reports a fault with vector 14 and gives no address. Writing the page-table base register (`base_wr_i`) invalidates every entry. This is how a context switch is handled.

A fill goes to one of three places, in this order of preference:
- the entry already holding the same page number;
- the lowest-numbered invalid entry;
- the entry named by a round-robin pointer, which starts at entry 0 after reset or a flush and advances only when it is used.

Top module: `tlb_xlate`

## Requirements
- R1: After reset every entry is invalid, so any lookup misses.
- R2: A lookup that matches a valid entry and is permitted raises `hit_o` in the same cycle, with `pa_o` = {stored frame number, `req_va_i[11:0]`}.
- R3: A lookup whose page number `req_va_i[31:12]` matches no valid entry raises `miss_o`, with `pa_o` = 0.
- R4: For a valid request exactly one of `hit_o`, `miss_o`, `fault_o` is high. With `req_valid_i` low, all three are low.
- R5: A user-mode lookup (`req_user_i`=1) that matches an entry stored with user=0 (supervisor only) raises `fault_o` with `fault_vec_o` = 14, and `hit_o` stays low. A supervisor-mode lookup of the same entry hits.
- R6: A write lookup (`req_write_i`=1) that matches an entry stored with writable=0 faults, in either mode. A read lookup of the same entry hits.
- R7: A fill (`fill_valid_i`) without a flush is visible to lookups from the next cycle on.
- R8: Once all entries are valid, a fill of a new page evicts entries in round-robin order starting at entry 0. The pointer starts at 0 after reset or a flush and moves only when it picks the victim.
- R9: A fill whose page number is already resident overwrites that entry's frame and rights, and no other entry is evicted.
- R10: A pulse on `base_wr_i` invalidates all entries, so lookups miss from the next cycle on.
- R11: When `base_wr_i` and `fill_valid_i` are high in the same cycle, the fill is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Lookup request present |
| req_va_i | input | 32 | Virtual address of the lookup |
| req_write_i | input | 1 | 1 = write access, 0 = read |
| req_user_i | input | 1 | 1 = user mode, 0 = supervisor |
| hit_o | output | 1 | Permitted translation found |
| miss_o | output | 1 | No valid entry matches; walk needed |
| fault_o | output | 1 | Entry found but access forbidden |
| fault_vec_o | output | 8 | 14 while `fault_o` is high, else 0 |
| pa_o | output | 32 | Physical address on hit, else 0 |
| fill_valid_i | input | 1 | Install a translation |
| fill_vpn_i | input | 20 | Virtual page number to install |
| fill_pfn_i | input | 20 | Physical frame number to install |
| fill_user_i | input | 1 | 1 = page reachable from user mode |
| fill_writable_i | input | 1 | 1 = page writable |
| base_wr_i | input | 1 | Page-table base write; flushes all entries |

## Verification
A flush and a fill can land in the same cycle, and so can a fill and a lookup. The first case is provoked by raising `base_wr_i` together with a fill of a fresh page. It is judged by a lookup of that page one cycle later, which must miss. A flush on its own is judged the same way, on a page that was hitting just before. Round-robin eviction is judged by filling past capacity and observing which earlier pages now miss. The rights check is judged by lookups of the same resident page under every combination of mode and access type.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned VA_W   = 32;
  localparam int unsigned OFF_W  = 12;
  localparam int unsigned VPN_W  = VA_W - OFF_W;
  localparam int unsigned PFN_W  = 20;
  localparam int unsigned PA_W   = PFN_W + OFF_W;
  localparam int unsigned VEC_W  = 8;
  localparam logic [VEC_W-1:0] PF_VEC = 8'd14;

  typedef struct packed {
    logic             valid;
    logic [VPN_W-1:0] vpn;
    logic [PFN_W-1:0] pfn;
    logic             user;
    logic             writable;
  } tlb_entry_t;
endpackage

// File: rtl/tlb_match.sv
module tlb_match
  import tlb_pkg::*;
#(
  parameter int unsigned ENTRIES = 8,
  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  tlb_entry_t [ENTRIES-1:0] entries_i,
  input  logic [VPN_W-1:0]         vpn_i,
  output logic                     any_o,
  output logic [IDX_W-1:0]         idx_o,
  output tlb_entry_t               entry_o
);
  logic [ENTRIES-1:0] match;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = entries_i[g].valid && (entries_i[g].vpn == vpn_i);
  end

  assign any_o = |match;

  // entries are unique by page number, so an OR-mux is safe
  always_comb begin
    idx_o   = '0;
    entry_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) begin
        idx_o   = IDX_W'(i);
        entry_o = entry_o | entries_i[i];
      end
    end
  end
endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel #(
  parameter int unsigned ENTRIES = 8,
  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               flush_i,
  input  logic               fill_i,
  input  logic [ENTRIES-1:0] valid_i,
  input  logic               resident_i,
  input  logic [IDX_W-1:0]   resident_idx_i,
  output logic [IDX_W-1:0]   idx_o
);
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] free_idx;
  logic             free_any;
  logic             use_rr;

  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  assign use_rr = !resident_i && !free_any;
  assign idx_o  = resident_i ? resident_idx_i : (free_any ? free_idx : rr_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 rr_q <= '0;
    else if (flush_i)            rr_q <= '0;
    else if (fill_i && use_rr)   rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
  end
endmodule

// File: rtl/tlb_perm_chk.sv
module tlb_perm_chk (
  input  logic entry_user_i,
  input  logic entry_writable_i,
  input  logic req_user_i,
  input  logic req_write_i,
  output logic deny_o
);
  assign deny_o = (req_user_i && !entry_user_i) || (req_write_i && !entry_writable_i);
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int unsigned ENTRIES = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [VA_W-1:0]  req_va_i,
  input  logic             req_write_i,
  input  logic             req_user_i,
  output logic             hit_o,
  output logic             miss_o,
  output logic             fault_o,
  output logic [VEC_W-1:0] fault_vec_o,
  output logic [PA_W-1:0]  pa_o,
  input  logic             fill_valid_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PFN_W-1:0] fill_pfn_i,
  input  logic             fill_user_i,
  input  logic             fill_writable_i,
  input  logic             base_wr_i
);
  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  tlb_entry_t [ENTRIES-1:0] ent_q;
  logic [ENTRIES-1:0]       valid_vec;

  logic                     lk_any;
  logic [IDX_W-1:0]         lk_idx;
  tlb_entry_t               lk_ent;
  logic                     deny;

  logic                     fl_res;
  logic [IDX_W-1:0]         fl_res_idx;
  tlb_entry_t               fl_ent_unused;
  logic [IDX_W-1:0]         victim;
  logic                     fill_go;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_vld
    assign valid_vec[g] = ent_q[g].valid;
  end

  tlb_match #(.ENTRIES(ENTRIES)) u_lk_match (
    .entries_i (ent_q),
    .vpn_i     (req_va_i[VA_W-1:OFF_W]),
    .any_o     (lk_any),
    .idx_o     (lk_idx),
    .entry_o   (lk_ent)
  );

  tlb_perm_chk u_perm (
    .entry_user_i     (lk_ent.user),
    .entry_writable_i (lk_ent.writable),
    .req_user_i       (req_user_i),
    .req_write_i      (req_write_i),
    .deny_o           (deny)
  );

  tlb_match #(.ENTRIES(ENTRIES)) u_fl_match (
    .entries_i (ent_q),
    .vpn_i     (fill_vpn_i),
    .any_o     (fl_res),
    .idx_o     (fl_res_idx),
    .entry_o   (fl_ent_unused)
  );

  assign fill_go = fill_valid_i && !base_wr_i;  // flush wins

  tlb_victim_sel #(.ENTRIES(ENTRIES)) u_victim (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .flush_i        (base_wr_i),
    .fill_i         (fill_go),
    .valid_i        (valid_vec),
    .resident_i     (fl_res),
    .resident_idx_i (fl_res_idx),
    .idx_o          (victim)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ent_q <= '0;
    end else if (base_wr_i) begin
      for (int i = 0; i < ENTRIES; i++) ent_q[i].valid <= 1'b0;
    end else if (fill_go) begin
      ent_q[victim] <= '{valid: 1'b1, vpn: fill_vpn_i, pfn: fill_pfn_i,
                         user: fill_user_i, writable: fill_writable_i};
    end
  end

  assign hit_o       = req_valid_i && lk_any && !deny;
  assign fault_o     = req_valid_i && lk_any && deny;
  assign miss_o      = req_valid_i && !lk_any;
  assign fault_vec_o = fault_o ? PF_VEC : '0;
  assign pa_o        = hit_o ? {lk_ent.pfn, req_va_i[OFF_W-1:0]} : '0;

  logic unused_idx;
  assign unused_idx = ^lk_idx;
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk
  import tlb_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic [VA_W-1:0]  req_va_i,
  input logic             req_write_i,
  input logic             req_user_i,
  input logic             hit_o,
  input logic             miss_o,
  input logic             fault_o,
  input logic [VEC_W-1:0] fault_vec_o,
  input logic [PA_W-1:0]  pa_o,
  input logic             fill_valid_i,
  input logic [VPN_W-1:0] fill_vpn_i,
  input logic [PFN_W-1:0] fill_pfn_i,
  input logic             fill_user_i,
  input logic             fill_writable_i,
  input logic             base_wr_i
);
  p_one_outcome_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> $countones({hit_o, miss_o, fault_o}) == 1);

  p_idle_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> !hit_o && !miss_o && !fault_o);

  p_fault_vec_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> fault_vec_o == PF_VEC);

  p_offset_pass_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> pa_o[OFF_W-1:0] == req_va_i[OFF_W-1:0]);

  p_miss_no_pa_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |-> pa_o == '0);

  p_fill_seen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && !base_wr_i) |=>
      ((req_valid_i && req_va_i[VA_W-1:OFF_W] == $past(fill_vpn_i)) |-> !miss_o));

  p_flush_empty_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    base_wr_i |=> (req_valid_i |-> miss_o));

  logic unused;
  assign unused = req_write_i ^ req_user_i ^ fill_user_i ^ fill_writable_i ^ (^fill_pfn_i);
endmodule

bind tlb_xlate tlb_xlate_chk u_chk (.*);

// File: tb/sim_tlb_xlate.sv
`timescale 1ns/1ps
module sim_tlb_xlate;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0;
  logic [31:0] req_va = '0;
  logic        req_write = 0, req_user = 0;
  logic        hit, miss, fault;
  logic [7:0]  fvec;
  logic [31:0] pa;
  logic        fill_valid = 0;
  logic [19:0] fill_vpn = '0, fill_pfn = '0;
  logic        fill_user = 0, fill_wr = 0;
  logic        base_wr = 0;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tlb_xlate u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_va_i(req_va),
    .req_write_i(req_write), .req_user_i(req_user), .hit_o(hit), .miss_o(miss),
    .fault_o(fault), .fault_vec_o(fvec), .pa_o(pa), .fill_valid_i(fill_valid),
    .fill_vpn_i(fill_vpn), .fill_pfn_i(fill_pfn), .fill_user_i(fill_user),
    .fill_writable_i(fill_wr), .base_wr_i(base_wr)
  );

  task automatic chk(string req, logic [42:0] act, logic [42:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // outcome packed as {hit,miss,fault,vec[7:0],pa[31:0]}
  task automatic look(string req, logic [31:0] va, logic wr, logic usr,
                      logic eh, logic em, logic ef, logic [31:0] epa);
    @(negedge clk);
    req_valid = 1; req_va = va; req_write = wr; req_user = usr;
    #1;
    chk(req, {hit, miss, fault, fvec, pa}, {eh, em, ef, (ef ? 8'd14 : 8'd0), epa});
    req_valid = 0;
  endtask

  task automatic fill(logic [19:0] vpn, logic [19:0] pfn, logic u, logic w, logic fl);
    @(negedge clk);
    fill_valid = 1; fill_vpn = vpn; fill_pfn = pfn; fill_user = u; fill_wr = w; base_wr = fl;
    @(negedge clk);
    fill_valid = 0; base_wr = 0;
  endtask

  task automatic flush();
    @(negedge clk); base_wr = 1;
    @(negedge clk); base_wr = 0;
  endtask

  task automatic t_reset();
    look("R1", 32'h1234_5678, 0, 0, 0, 1, 0, 32'h0);
    look("R3", 32'h0000_0000, 1, 1, 0, 1, 0, 32'h0);
  endtask

  task automatic t_idle();
    @(negedge clk);
    req_valid = 0; req_va = 32'h1234_5678; #1;
    chk("R4", {hit, miss, fault, fvec, pa}, 43'h0);
  endtask

  task automatic t_hit();
    fill(20'h12345, 20'hABCDE, 1, 1, 0);
    look("R7", 32'h1234_5678, 0, 1, 1, 0, 0, 32'hABCD_E678);
    look("R2", 32'h1234_5FFF, 1, 0, 1, 0, 0, 32'hABCD_EFFF);
    look("R3", 32'h1234_6000, 0, 0, 0, 1, 0, 32'h0);
  endtask

  task automatic t_perm();
    fill(20'h00400, 20'h00111, 0, 1, 0);
    look("R5", 32'h0040_0010, 0, 1, 0, 0, 1, 32'h0);
    look("R5", 32'h0040_0010, 0, 0, 1, 0, 0, 32'h0011_1010);
    fill(20'h00500, 20'h00222, 1, 0, 0);
    look("R6", 32'h0050_0abc, 1, 1, 0, 0, 1, 32'h0);
    look("R6", 32'h0050_0abc, 1, 0, 0, 0, 1, 32'h0);
    look("R6", 32'h0050_0abc, 0, 1, 1, 0, 0, 32'h0022_2abc);
  endtask

  task automatic t_overwrite();
    fill(20'h00500, 20'h00333, 1, 1, 0);
    look("R9", 32'h0050_0abc, 1, 1, 1, 0, 0, 32'h0033_3abc);
    look("R9", 32'h1234_5678, 0, 0, 1, 0, 0, 32'hABCD_E678);
    look("R9", 32'h0040_0010, 0, 0, 1, 0, 0, 32'h0011_1010);
  endtask

  task automatic t_flush();
    flush();
    look("R10", 32'h1234_5678, 0, 0, 0, 1, 0, 32'h0);
    look("R10", 32'h0050_0abc, 0, 0, 0, 1, 0, 32'h0);
  endtask

  task automatic t_flush_fill();
    fill(20'h00777, 20'h00999, 1, 1, 1);
    look("R11", 32'h0077_7000, 0, 0, 0, 1, 0, 32'h0);
  endtask

  task automatic t_repl();
    for (int i = 0; i < 8; i++) fill(20'h00100 + 20'(i), 20'h00A00 + 20'(i), 1, 1, 0);
    for (int i = 0; i < 8; i++)
      look("R8", {20'h00100 + 20'(i), 12'h004}, 0, 1, 1, 0, 0, {20'h00A00 + 20'(i), 12'h004});
    fill(20'h00108, 20'h00A08, 1, 1, 0);
    look("R8", 32'h0010_0004, 0, 1, 0, 1, 0, 32'h0);
    look("R8", 32'h0010_8004, 0, 1, 1, 0, 0, 32'h00A0_8004);
    look("R8", 32'h0010_1004, 0, 1, 1, 0, 0, 32'h00A0_1004);
    fill(20'h00109, 20'h00A09, 1, 1, 0);
    look("R8", 32'h0010_1004, 0, 1, 0, 1, 0, 32'h0);
    look("R8", 32'h0010_2004, 0, 1, 1, 0, 0, 32'h00A0_2004);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_idle();
    t_hit();
    t_perm();
    t_overwrite();
    t_flush();
    t_flush_fill();
    t_repl();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule